// File: doc/BRIEF.md
# Bit-granular masked width packer

This block collects narrow input words and emits wider output words. Each input word carries a bit mask whose set bits form one unbroken run. Only the bits under the mask are kept. They are shifted down to bit 0 and appended directly above the bits already held, so packing runs from the LSB upward. When at least one output word's worth of bits is held, the lowest bits leave as an output word with an all-ones mask, and the higher bits that remain move down and wait for the next word. The input and output widths are separate parameters, and neither has to be a multiple of the other.

Both data sides use valid/ready handshakes, and a word moves only in a cycle where valid and ready are both high. Back-pressure is kept deliberately coarse. The input side is ready only while the output side is ready, even if there would be room for another input word. The output holds its valid, data and mask steady while stalled.

A flush request drains whatever is still held. Any full words leave first. The remaining bits then leave as one final word whose mask covers only those bits. A one-cycle completion pulse follows once the block is empty. Input is refused in the request cycle and for as long as the drain lasts.

Top module: `lsb_bit_packer`

## Requirements
- R1: After reset, `out_valid` and `flush_done` are low, no bits are held, and `in_ready` follows `out_ready`.
- R2: An accepted input adds only the bits under `in_mask`, whose set bits form one contiguous run. The run is moved down so that its lowest masked bit lands directly above the held bits. Data bits outside the mask have no effect. An all-zero mask adds nothing.
- R3: The held bit count never exceeds IN_W+OUT_W. `in_ready` is low in every cycle where `out_ready` is low.
- R4: Whenever at least OUT_W bits are held, `out_valid` is high. `out_data` is then the lowest OUT_W held bits, `out_mask` is all ones, and after the transfer the leftover bits move down and are kept in order.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_mask` stay unchanged into the next cycle.
- R6: After a flush request, any full words leave first. If k held bits remain, with 0<k<OUT_W, they leave as one word in bits k-1..0 with `out_mask` bits k-1..0 set and all higher bits clear.
- R7: `flush_done` is a one-cycle pulse in the cycle after the drain empties the block. If nothing is held when flush is requested, that is the cycle after the request. In the pulse cycle `out_valid` is low and no bits are held.
- R8: `in_ready` is low in the cycle `flush_req` is high and in every cycle until `flush_done` pulses.
- R9: An input word is taken only in a cycle where `in_valid` and `in_ready` are both high. A word presented while `in_ready` is low adds no bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word offered |
| in_data | input | IN_W | Input data bits |
| in_mask | input | IN_W | Contiguous run of valid input bits |
| in_ready | output | 1 | Block accepts an input word this cycle |
| out_valid | output | 1 | Output word offered |
| out_data | output | OUT_W | Packed output bits, LSB first |
| out_mask | output | OUT_W | Valid bits of the output word |
| out_ready | input | 1 | Downstream accepts the output word |
| flush_req | input | 1 | Request to drain all held bits |
| flush_done | output | 1 | One-cycle pulse when the drain has finished |

## Verification
The in-line assertions check the rules that hold on every cycle. These are the bound on the held bit count, the clear storage above that count, the coupling of input ready to output ready, the stall stability of the output, the all-ones mask outside a drain, and the empty, idle state at each completion pulse. Only the bench's scenarios can show that the bit stream comes out in the right order across a 4-to-6 width mismatch, which needs a reference model. The same holds for what masked-off data bits and refused inputs leave behind, and for the exact mask of the partial final word after a flush under random back-pressure.

// File: rtl/lbp_pkg.sv
package lbp_pkg;
  typedef enum logic {
    FL_IDLE  = 1'b0,
    FL_DRAIN = 1'b1
  } flush_state_e;
endpackage

// File: rtl/lbp_align.sv
// Extracts the contiguous masked run of an input word and moves it to bit 0.
module lbp_align #(
  parameter int IN_W  = 4,
  parameter int LEN_W = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [IN_W-1:0]  in_mask,
  output logic [IN_W-1:0]  aligned,
  output logic [LEN_W-1:0] run_len
);
  int  lo_pos;
  logic found;

  always_comb begin
    lo_pos  = 0;
    found   = 1'b0;
    run_len = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (in_mask[i]) begin
        if (!found) lo_pos = i;
        found   = 1'b1;
        run_len = run_len + LEN_W'(1);
      end
    end
    aligned = (in_data & in_mask) >> lo_pos;
  end

  // R2: the moved run occupies no bit at or above its length
  assert_run_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((aligned >> run_len) == '0));
endmodule

// File: rtl/lbp_store.sv
// Holding register, bit count, output word and mask formation.
module lbp_store #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 6,
  parameter int LEN_W = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             flushing,
  input  logic             out_ready,
  input  logic [IN_W-1:0]  aligned,
  input  logic [LEN_W-1:0] run_len,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic [OUT_W-1:0] out_mask,
  output logic             room_ok,
  output logic             empty_next
);
  localparam int ST_W  = IN_W + OUT_W;
  localparam int CNT_W = $clog2(ST_W + 1);

  logic [ST_W-1:0]  store_q, store_base, store_next;
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_next, pop_n;
  logic             full, pop;

  always_comb begin
    full       = cnt_q >= CNT_W'(OUT_W);
    out_valid  = full || (flushing && cnt_q != '0);
    pop_n      = full ? CNT_W'(OUT_W) : cnt_q;
    pop        = out_valid && out_ready;
    cnt_base   = pop ? cnt_q - pop_n : cnt_q;
    store_base = pop ? store_q >> pop_n : store_q;
    cnt_next   = acc ? cnt_base + CNT_W'(run_len) : cnt_base;
    store_next = acc ? (store_base | (ST_W'(aligned) << cnt_base)) : store_base;
    empty_next = cnt_next == '0;
    out_data   = store_q[OUT_W-1:0];
    for (int i = 0; i < OUT_W; i++) out_mask[i] = full || (CNT_W'(i) < cnt_q);
  end

  generate
    if (IN_W <= OUT_W) begin : g_room_free
      assign room_ok = 1'b1;
    end else begin : g_room_chk
      assign room_ok = (full ? cnt_q - CNT_W'(OUT_W) : cnt_q) <= CNT_W'(OUT_W);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      cnt_q   <= '0;
    end else begin
      store_q <= store_next;
      cnt_q   <= cnt_next;
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ST_W));

  // R2: storage above the held count stays clear
  assert_upper_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_q >> cnt_q) == '0);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mask));
endmodule

// File: rtl/lbp_ctrl.sv
// Flush sequencing and input-side ready.
module lbp_ctrl
  import lbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush_req,
  input  logic out_ready,
  input  logic room_ok,
  input  logic empty_next,
  output logic in_ready,
  output logic flushing,
  output logic flush_done
);
  flush_state_e state_q, state_d;
  logic         done_d;

  assign flushing = (state_q == FL_DRAIN);
  assign in_ready = out_ready && room_ok && !flush_req && !flushing;

  always_comb begin
    state_d = FL_IDLE;
    done_d  = 1'b0;
    if (flush_req || flushing) begin
      if (empty_next) done_d  = 1'b1;
      else            state_d = FL_DRAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= FL_IDLE;
      flush_done <= 1'b0;
    end else begin
      state_q    <= state_d;
      flush_done <= done_d;
    end
  end

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> $past(flush_req || state_q == FL_DRAIN));
endmodule

// File: rtl/lsb_bit_packer.sv
module lsb_bit_packer #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [IN_W-1:0]  in_mask,
  output logic             in_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic [OUT_W-1:0] out_mask,
  input  logic             out_ready,
  input  logic             flush_req,
  output logic             flush_done
);
  localparam int LEN_W = $clog2(IN_W + 1);

  logic [IN_W-1:0]  aligned;
  logic [LEN_W-1:0] run_len;
  logic             acc, flushing, room_ok, empty_next;

  assign acc = in_valid && in_ready;

  lbp_align #(.IN_W(IN_W), .LEN_W(LEN_W)) u_align (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .in_mask(in_mask),
    .aligned(aligned), .run_len(run_len)
  );

  lbp_store #(.IN_W(IN_W), .OUT_W(OUT_W), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .acc(acc), .flushing(flushing),
    .out_ready(out_ready), .aligned(aligned), .run_len(run_len),
    .out_valid(out_valid), .out_data(out_data), .out_mask(out_mask),
    .room_ok(room_ok), .empty_next(empty_next)
  );

  lbp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .out_ready(out_ready),
    .room_ok(room_ok), .empty_next(empty_next),
    .in_ready(in_ready), .flushing(flushing), .flush_done(flush_done)
  );

  assert_ready_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);

  assert_full_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !flushing |-> (&out_mask));

  assert_done_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !out_valid);
endmodule

// File: tb/lsb_bit_packer_test.sv
module lsb_bit_packer_test;
  localparam int IN_W  = 4;
  localparam int OUT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0, in_mask = '0;
  logic in_ready, out_valid, flush_done;
  logic [OUT_W-1:0] out_data, out_mask;
  logic out_ready = 1'b1;
  logic flush_req = 1'b0;

  int checks = 0, fails = 0, cycles = 0;
  bit bp_on = 1'b0, force_low = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  bit mq[$];
  logic [OUT_W-1:0] exp_d[$], exp_m[$];

  bit hold_prev = 1'b0;
  logic [OUT_W-1:0] prev_d, prev_m;

  always #10 clk = ~clk;  // 50 MHz

  lsb_bit_packer #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_mask(in_mask), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_mask(out_mask), .out_ready(out_ready),
    .flush_req(flush_req), .flush_done(flush_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // downstream ready pattern
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = force_low ? 1'b0 : (bp_on ? (lfsr[0] | lfsr[1]) : 1'b1);
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // monitor: compares produced words with the scoreboard
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      if (hold_prev)  // R5
        check(out_valid && out_data == prev_d && out_mask == prev_m, "R5 stall hold",
              out_data, prev_d);
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) check(1'b0, "R4 unexpected output word", out_data, 0);
        else begin
          logic [OUT_W-1:0] ed, em;
          ed = exp_d.pop_front();
          em = exp_m.pop_front();
          // R4 full words / R6 partial word
          check(out_data == ed, "R4/R6 data", out_data, ed);
          check(out_mask == em, "R4/R6 mask", out_mask, em);
        end
      end
      hold_prev = out_valid && !out_ready;
      prev_d = out_data;
      prev_m = out_mask;
    end
  end

  task automatic model_push(input logic [IN_W-1:0] d, input logic [IN_W-1:0] m);
    for (int i = 0; i < IN_W; i++) if (m[i]) mq.push_back(d[i]);
    while (mq.size() >= OUT_W) begin
      logic [OUT_W-1:0] w;
      for (int b = 0; b < OUT_W; b++) w[b] = mq.pop_front();
      exp_d.push_back(w);
      exp_m.push_back('1);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic send(input logic [IN_W-1:0] d, input logic [IN_W-1:0] m);
    bit took;
    in_valid = 1'b1;
    in_data  = d;
    in_mask  = m;
    forever begin
      #5;
      took = in_ready;
      if (!out_ready) check(!in_ready, "R3 ready gate", in_ready, 0);
      if (took) model_push(d, m);  // R9: taken only with valid and ready high
      @(negedge clk);
      if (took) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic flush();
    bit seen = 1'b0;
    if (mq.size() > 0) begin
      logic [OUT_W-1:0] w, mk;
      int n;
      w = '0; mk = '0; n = mq.size();
      for (int b = 0; b < n; b++) begin w[b] = mq.pop_front(); mk[b] = 1'b1; end
      exp_d.push_back(w);
      exp_m.push_back(mk);
    end
    flush_req = 1'b1;
    #5;
    check(!in_ready, "R8 ready low in request cycle", in_ready, 0);
    @(negedge clk);
    flush_req = 1'b0;
    for (int c = 0; c < 200; c++) begin
      #5;
      if (flush_done) begin seen = 1'b1; break; end
      check(!in_ready, "R8 ready low while draining", in_ready, 0);
      @(negedge clk);
    end
    check(seen, "R7 flush_done pulse seen", seen, 1);
    check(!out_valid, "R7 no output at done", out_valid, 0);
    check(exp_d.size() == 0, "R6 all held bits drained", exp_d.size(), 0);
    @(negedge clk);
    #5;
    check(!flush_done, "R7 done is one cycle", flush_done, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1 reset state
    check(!out_valid, "R1 out_valid low", out_valid, 0);
    check(!flush_done, "R1 flush_done low", flush_done, 0);
    check(in_ready == out_ready, "R1 in_ready follows out_ready", in_ready, out_ready);
    @(negedge clk);

    // 4-in/6-out stream with full masks: 0,1,2 give 0x10 then 0x08 (R2, R4)
    for (int v = 0; v < 7; v++) send(IN_W'(v), '1);
    flush();  // 4 bits left: partial mask 0x0F (R6)

    // empty flush (R7)
    flush();

    // exact multiple: 12 bits form two words, nothing left (R4, R7)
    send(4'hA, '1); send(4'h5, '1); send(4'hC, '1);
    flush();

    // masked runs with junk outside the mask under back-pressure (R2, R3, R5)
    bp_on = 1'b1;
    for (int i = 0; i < 60; i++) begin
      int len, lo;
      logic [IN_W-1:0] m;
      len = (i % IN_W) + 1;
      lo  = (i / 3) % (IN_W - len + 1);
      m   = IN_W'(((1 << len) - 1) << lo);
      send(IN_W'(i * 7 + 3), m);
    end
    send(4'hF, 4'h0);  // R2 empty mask adds nothing
    send(4'b1011, 4'b0110);
    flush();

    // stray input while in_ready is low adds nothing (R9)
    send(4'h3, '1);
    force_low = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_data = 4'hF; in_mask = 4'hF;
    for (int c = 0; c < 3; c++) begin
      #5;
      check(!in_ready, "R9 refused while out_ready low", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    force_low = 1'b0;
    bp_on = 1'b0;
    @(negedge clk);
    flush();  // only the 4 bits of 0x3 come out (R9, R6)

    check(exp_d.size() == 0, "R4 scoreboard empty at end", exp_d.size(), 0);
    finish_run();
  end
endmodule